// File: doc/BRIEF.md
# Vertical Blanking and Flutter-Gate Generator

This block turns the state of a field divider into the vertical timing pulses of a deflection controller. The divider counts half-lines: one line is two counts. Each field, the divider presents its count together with a one-cycle strobe that marks the count-zero cycle after a divider reset. It also reports its operating mode (wide search, narrow window or locked standard) and whether the field rate is 50 Hz or 60 Hz.

The block produces four pulses from these inputs. The first is a gate that inhibits the line phase comparator around vertical sync. The second is the vertical blanking pulse, and the third is the 26-count charge window for the field sawtooth. The fourth is a combined vertical level that feeds a two-bit sandcastle-style code, which a later stage converts to voltage levels.

The gate can start early. In the two predictive modes (narrow and standard) it opens a few counts before the expected reset, where the first equalizing pulse is due. A fault flag from an out-of-range feedback comparator holds the coded output at the vertical blanking level for as long as the fault lasts.

Top module: `vblank_gate_gen`

## Requirements
- R1: While rst_n is low, atf_gate, vblank, charge_win and vblank_sc are 0, and sc_code is 00 when hblank_in and burst_in are low.
- R2: vblank rises one clock after a cycle with div_rst high. It stays high for the cycles that follow counts 0 through VB_END-1, where VB_END is 44 when rate_50=1 and 34 when rate_50=0.
- R3: In search mode (div_mode=00), atf_gate rises only one clock after div_rst. It stays high for the cycles that follow counts 0 through ATF_END-1, where ATF_END is 8 when rate_50=1 and 10 when rate_50=0.
- R4: In narrow mode (div_mode=01) and standard mode (div_mode=10), atf_gate also rises one clock after the count equals the standard field length minus 6, which is 619 at 50 Hz and 519 at 60 Hz. It stays high through the divider wrap until count ATF_END is seen.
- R5: charge_win rises one clock after div_rst and is high for exactly the cycles that follow counts 0 through 25.
- R6: Each of these pulses is cleared only by its own end count. A field longer than the standard length keeps the early-started gate high until the wrap.
- R7: div_mode=11 behaves as search mode: there is no early gate start.
- R8: vblank_sc is the OR of atf_gate, vblank and the registered guard fault.
- R9: One clock after guard_fault is high, vblank_sc is 1 and sc_code is 10, whatever burst_in and hblank_in are.
- R10: sc_code encodes 11 for burst key, 10 for vertical blank, 01 for horizontal blank and 00 for none. The priority is burst key over vertical blank over horizontal blank. The fault of R9 overrides all of these.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cnt | input | CNT_W | Current divider count |
| div_rst | input | 1 | Strobe in the count-zero cycle after a divider reset |
| div_mode | input | 2 | Divider mode: 00 search, 01 narrow, 10 standard, 11 treated as search |
| rate_50 | input | 1 | 1 = 50 Hz field, 0 = 60 Hz field |
| guard_fault | input | 1 | Out-of-range feedback flag |
| hblank_in | input | 1 | Horizontal blanking request |
| burst_in | input | 1 | Burst-key request |
| atf_gate | output | 1 | Phase comparator inhibit gate |
| vblank | output | 1 | Vertical blanking pulse |
| charge_win | output | 1 | Sawtooth charge window |
| vblank_sc | output | 1 | Combined vertical level |
| sc_code | output | 2 | Coded sandcastle level |

## Verification
The three pulses and the registered fault are each due exactly one clock after the count, strobe, mode or fault that causes them. sc_code adds no further delay to the burst and horizontal requests, which act in the same cycle they are presented. The bench drives every input on the falling edge and checks at the next falling edge against the values it drove one cycle earlier. As a result, a single rising edge always lies between stimulus and check. The expected value of each output is worked out from the count alone, using the window limits stated in the requirements.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

  typedef enum logic [1:0] {
    MODE_SEARCH = 2'b00,
    MODE_NARROW = 2'b01,
    MODE_STD    = 2'b10,
    MODE_ALT    = 2'b11
  } vmode_e;

  typedef enum logic [1:0] {
    SC_NONE   = 2'b00,
    SC_HBLANK = 2'b01,
    SC_VBLANK = 2'b10,
    SC_BURST  = 2'b11
  } sc_code_e;

  // Pick the 50 Hz or 60 Hz value of a rate-dependent limit.
  function automatic int rate_pick(input logic is50, input int v50, input int v60);
    return is50 ? v50 : v60;
  endfunction

  // Count at which the first equalizing pulse is expected in predictive modes.
  function automatic int early_point(input logic is50, input int std50,
                                     input int std60, input int lead);
    return rate_pick(is50, std50, std60) - lead;
  endfunction

  // Narrow and standard modes anticipate the field reset; the others do not.
  function automatic logic is_predictive(input logic [1:0] m);
    return (m == MODE_NARROW) || (m == MODE_STD);
  endfunction

endpackage

// File: rtl/vbg_flag.sv
module vbg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R6: a start event always wins over a coincident end count
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R6: an end count alone always closes the pulse
  p_clr_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/vbg_sc_enc.sv
module vbg_sc_enc (
  input  logic       guard_i,
  input  logic       vert_i,
  input  logic       burst_i,
  input  logic       hblank_i,
  output logic [1:0] code_o
);
  import vbg_pkg::*;

  sc_code_e code_w;

  always_comb begin
    if (guard_i)       code_w = SC_VBLANK;
    else if (burst_i)  code_w = SC_BURST;
    else if (vert_i)   code_w = SC_VBLANK;
    else if (hblank_i) code_w = SC_HBLANK;
    else               code_w = SC_NONE;
  end

  assign code_o = code_w;

  // R10: horizontal blank never shows while vertical blank is active
  always_comb begin
    p_hb_masked_r10: assert (!(vert_i && code_o == SC_HBLANK));
  end

endmodule

// File: rtl/vblank_gate_gen.sv
module vblank_gate_gen #(
  parameter int CNT_W   = 10,
  parameter int STD50   = 625,
  parameter int STD60   = 525,
  parameter int EQ_LEAD = 6,
  parameter int ATF50   = 8,
  parameter int ATF60   = 10,
  parameter int VB50    = 44,
  parameter int VB60    = 34,
  parameter int CHG_LEN = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_cnt,
  input  logic             div_rst,
  input  logic [1:0]       div_mode,
  input  logic             rate_50,
  input  logic             guard_fault,
  input  logic             hblank_in,
  input  logic             burst_in,
  output logic             atf_gate,
  output logic             vblank,
  output logic             charge_win,
  output logic             vblank_sc,
  output logic [1:0]       sc_code
);
  import vbg_pkg::*;

  localparam int NF    = 3;
  localparam int F_ATF = 0;
  localparam int F_VB  = 1;
  localparam int F_CHG = 2;
  localparam logic [CNT_W-1:0] CHG_END = CNT_W'(CHG_LEN);

  // Named internal events
  logic [CNT_W-1:0] atf_end_c, vb_end_c, early_c;
  logic             early_hit, atf_end_hit, vb_end_hit, chg_end_hit;
  logic [NF-1:0]    set_v, clr_v, q_v;
  logic             guard_q;

  assign atf_end_c   = CNT_W'(rate_pick(rate_50, ATF50, ATF60));
  assign vb_end_c    = CNT_W'(rate_pick(rate_50, VB50, VB60));
  assign early_c     = CNT_W'(early_point(rate_50, STD50, STD60, EQ_LEAD));
  assign early_hit   = is_predictive(div_mode) && (div_cnt == early_c);
  assign atf_end_hit = (div_cnt == atf_end_c);
  assign vb_end_hit  = (div_cnt == vb_end_c);
  assign chg_end_hit = (div_cnt == CHG_END);

  assign set_v[F_ATF] = div_rst | early_hit;
  assign set_v[F_VB]  = div_rst;
  assign set_v[F_CHG] = div_rst;
  assign clr_v[F_ATF] = atf_end_hit;
  assign clr_v[F_VB]  = vb_end_hit;
  assign clr_v[F_CHG] = chg_end_hit;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    vbg_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) guard_q <= 1'b0;
    else        guard_q <= guard_fault;
  end

  assign atf_gate   = q_v[F_ATF];
  assign vblank     = q_v[F_VB];
  assign charge_win = q_v[F_CHG];
  assign vblank_sc  = q_v[F_ATF] | q_v[F_VB] | guard_q;

  vbg_sc_enc u_enc (
    .guard_i  (guard_q),
    .vert_i   (vblank_sc),
    .burst_i  (burst_in),
    .hblank_i (hblank_in),
    .code_o   (sc_code)
  );

  // R2: blanking only opens after a divider reset
  p_vb_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> $past(div_rst));
  // R2: blanking closes at its rate-dependent end count
  p_vb_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && vb_end_hit && !div_rst) |=> !vblank);
  // R3 / R7: outside predictive modes the gate opens only at reset
  p_atf_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(atf_gate) && !is_predictive($past(div_mode))) |-> $past(div_rst));
  // R4: the early point opens the gate in predictive modes
  p_atf_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early_hit |=> atf_gate);
  // R5: the charge window closes at count CHG_LEN
  p_chg_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (charge_win && chg_end_hit && !div_rst) |=> !charge_win);
  // R9: a guard fault forces vertical blanking on the coded output
  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    guard_fault |=> (vblank_sc && sc_code == 2'b10));
  // R8 / R10: either vertical pulse yields the vertical or burst code
  p_vert_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (atf_gate || vblank) |-> (sc_code[1] == 1'b1));

endmodule

// File: tb/vblank_gate_gen_test.sv
module vblank_gate_gen_test;

  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] div_cnt = '0;
  logic             div_rst = 1'b0;
  logic [1:0]       div_mode = 2'b00;
  logic             rate_50 = 1'b0;
  logic             guard_fault = 1'b0;
  logic             hblank_in = 1'b0;
  logic             burst_in = 1'b0;
  logic             atf_gate, vblank, charge_win, vblank_sc;
  logic [1:0]       sc_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // values driven one cycle earlier
  bit p_valid = 1'b0;
  int p_c;
  int p_mode;
  bit p_r50, p_hb, p_bk, p_g;

  always #10 clk = ~clk;

  vblank_gate_gen uut (
    .clk(clk), .rst_n(rst_n), .div_cnt(div_cnt), .div_rst(div_rst),
    .div_mode(div_mode), .rate_50(rate_50), .guard_fault(guard_fault),
    .hblank_in(hblank_in), .burst_in(burst_in), .atf_gate(atf_gate),
    .vblank(vblank), .charge_win(charge_win), .vblank_sc(vblank_sc),
    .sc_code(sc_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s count=%0d actual=%0d expected=%0d", tag, p_c, act, exp);
    end
  endtask

  task automatic check_prev();
    int ae, ve, std, ex_code;
    bit pred, e_atf, e_vb, e_chg, e_sc;
    string atag;
    if (!p_valid) return;
    ae   = p_r50 ? 8 : 10;
    ve   = p_r50 ? 44 : 34;
    std  = p_r50 ? 625 : 525;
    pred = (p_mode == 1) || (p_mode == 2);
    e_atf = (p_c < ae) || (pred && p_c >= std - 6);
    e_vb  = p_c < ve;
    e_chg = p_c < 26;
    e_sc  = e_atf | e_vb | p_g;
    ex_code = p_g ? 2 : p_bk ? 3 : (e_atf | e_vb) ? 2 : p_hb ? 1 : 0;
    atag = pred ? "R4" : (p_mode == 3 ? "R7" : "R3");
    chk(atf_gate == e_atf, atag, atf_gate, e_atf);
    chk(vblank == e_vb, "R2", vblank, e_vb);
    chk(charge_win == e_chg, "R5", charge_win, e_chg);
    chk(vblank_sc == e_sc, p_g ? "R9" : "R8", vblank_sc, e_sc);
    chk(int'(sc_code) == ex_code, p_g ? "R9" : "R10", sc_code, ex_code);
  endtask

  task automatic run_field(input int m, input bit r50, input int len, input bit use_g);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      check_prev();
      div_cnt     = CNT_W'(c);
      div_rst     = (c == 0);
      div_mode    = 2'(m);
      rate_50     = r50;
      hblank_in   = (c % 7) < 2;
      burst_in    = (c % 11) == 3;
      guard_fault = use_g && c >= 100 && c < 130;
      p_valid = 1'b1; p_c = c; p_mode = m; p_r50 = r50;
      p_hb = hblank_in; p_bk = burst_in; p_g = guard_fault;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(atf_gate == 0 && vblank == 0 && charge_win == 0, "R1",
        {atf_gate, vblank, charge_win}, 0);
    chk(vblank_sc == 0 && sc_code == 2'b00, "R1", {vblank_sc, sc_code}, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        int std = r ? 625 : 525;
        bit pred = (m == 1) || (m == 2);
        // R6: one standard field, then a longer one
        run_field(m, bit'(r), std, 1'b0);
        run_field(m, bit'(r), pred ? std + 3 : 700, 1'b0);
      end
    end
    // R9: guard fault over part of a field in both rates
    run_field(0, 1'b1, 625, 1'b1);
    run_field(2, 1'b0, 525, 1'b1);
    @(negedge clk);
    check_prev();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule